// File: doc/BRIEF.md
# Polynomial-Noise Audio Channel

One tone-and-noise voice for a sound generator. A base-rate tick enable (nominally near 30 kHz) feeds a programmable 5-bit rate divider. Each output pulse of that divider advances a small set of waveform sources: three maximal-length shift-register noise generators (4, 5 and 9 bits) and one shared modulo counter. A 4-bit control code decides which source drives the 1-bit waveform. It also decides which source gates the advance of another, and so forms a cascade. The output is a 4-bit amplitude: the volume setting while the waveform is high, zero while it is low.

Software-side logic writes three settings through one narrow write port: the rate divisor, the control code and the volume. Mixing with other voices and driving an analog pin are left to the surrounding logic.

Top module: `poly_audio_voice`

## Requirements
- R1: After a synchronous active-low reset, amp_out is 0, all settings are 0, the rate prescaler and shared counter are 0, and each shift register holds all ones.
- R2: With divisor N (0..31) written at address 0, the voice advances once every N+1 ticks of tick_en; the prescaler counts ticks and fires when its count is at or above N, then restarts from 0.
- R3: Control codes 0x0 and 0xB hold the waveform at 1.
- R4: Codes 0x1, 0x9 and 0x8 output the top bit of the 4-, 5- and 9-bit registers, each shifting left on every advance with new bit s[3]^s[2], s[4]^s[2] and s[8]^s[4] respectively.
- R5: Code 0x2 advances the 4-bit register only on the advance at which the shared counter (mod 15) is at 14, and outputs its top bit.
- R6: Code 0x3 advances the 4-bit register only on advances where the 5-bit register's top bit is 1, and outputs the 4-bit top bit.
- R7: Pure divider codes use the shared counter d counting 0..P-1 on every advance, with the waveform high while d >= P/2 (integer): P=2 for 0x4 and 0x5, P=31 for 0x6 and 0xA, P=6 for 0xC and 0xD, P=93 for 0xE.
- R8: Codes 0x7 (P=2) and 0xF (P=6) step the shared counter only on advances where the 5-bit register's top bit is 1; the waveform rule is the same as in R7.
- R9: amp_out equals the volume (address 2, 0..15) one clock after the waveform state is high, and 0 otherwise.
- R10: A write to the control code (address 1) clears the shared counter to 0 and leaves the shift registers unchanged.
- R11: A write to address 3 changes no setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Base-rate tick enable, one clock wide |
| wr_en | input | 1 | Setting write strobe |
| wr_addr | input | 2 | 0 divisor, 1 control code, 2 volume, 3 unused |
| wr_data | input | 5 | Write data; control and volume use bits 3:0 |
| amp_out | output | 4 | Registered output amplitude |

## Verification
A wrong shift-register tap or seed shows as a different high/low pattern in amp_out within the first few advances in a noise mode. The pattern then drifts further off for the rest of the register period: 15, 31 or 511 advances. A miscounted prescaler or shared counter moves each waveform edge by a whole number of ticks, so the first edge after a control write already lands in the wrong tick. A gating error in a cascade mode appears at the first advance where the 5-bit top bit or the mod-15 wrap disagrees with the model. Each of these shows at the next amp_out sample, one clock after the state update.

// File: rtl/pav_pkg.sv
// Shared types for the polynomial-noise voice.
// Assumes a 4-bit control code; the decode below is the single place
// where a code maps onto waveform source, gating and modulus.
package pav_pkg;

    localparam int MOD_W = 7;

    typedef enum logic [1:0] {
        REG_FREQ = 2'd0,
        REG_CTRL = 2'd1,
        REG_VOL  = 2'd2,
        REG_NONE = 2'd3
    } reg_addr_e;

    typedef enum logic [2:0] {
        SRC_ONE,
        SRC_P4,
        SRC_P5,
        SRC_P9,
        SRC_DIV
    } wave_src_e;

    typedef enum logic [1:0] {
        P4_EVERY,
        P4_ON_WRAP,
        P4_ON_P5
    } p4_clk_e;

    typedef struct packed {
        wave_src_e        src;
        p4_clk_e          p4_clk;
        logic             div_on_p5;
        logic [MOD_W-1:0] modulus;
    } voice_cfg_t;

    // Map a control code onto the voice configuration.
    function automatic voice_cfg_t decode_ctrl(input logic [3:0] code);
        voice_cfg_t cfg;
        cfg.src       = SRC_ONE;
        cfg.p4_clk    = P4_EVERY;
        cfg.div_on_p5 = 1'b0;
        cfg.modulus   = MOD_W'(1);
        case (code)
            4'h1: cfg.src = SRC_P4;
            4'h2: begin
                cfg.src     = SRC_P4;
                cfg.p4_clk  = P4_ON_WRAP;
                cfg.modulus = MOD_W'(15);
            end
            4'h3: begin
                cfg.src    = SRC_P4;
                cfg.p4_clk = P4_ON_P5;
            end
            4'h4, 4'h5: begin
                cfg.src     = SRC_DIV;
                cfg.modulus = MOD_W'(2);
            end
            4'h6, 4'hA: begin
                cfg.src     = SRC_DIV;
                cfg.modulus = MOD_W'(31);
            end
            4'h7: begin
                cfg.src       = SRC_DIV;
                cfg.div_on_p5 = 1'b1;
                cfg.modulus   = MOD_W'(2);
            end
            4'h8: cfg.src = SRC_P9;
            4'h9: cfg.src = SRC_P5;
            4'hC, 4'hD: begin
                cfg.src     = SRC_DIV;
                cfg.modulus = MOD_W'(6);
            end
            4'hE: begin
                cfg.src     = SRC_DIV;
                cfg.modulus = MOD_W'(93);
            end
            4'hF: begin
                cfg.src       = SRC_DIV;
                cfg.div_on_p5 = 1'b1;
                cfg.modulus   = MOD_W'(6);
            end
            default: cfg.src = SRC_ONE;
        endcase
        return cfg;
    endfunction

endpackage

// File: rtl/pav_rate_div.sv
// Rate prescaler: emits one-clock advance pulses at tick rate / (N+1).
// Assumes tick_en is a one-clock strobe; a divisor lowered below the
// running count fires on the next tick (>= compare) rather than wrapping.
module pav_rate_div #(
    parameter int FW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_en,
    input  logic [FW-1:0] div_val,
    output logic          step
);

    logic [FW-1:0] cnt_q;

    // Fire when the tick count has reached the divisor.
    always_comb step = tick_en && (cnt_q >= div_val);

    // Count ticks, restart after each fire.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (tick_en) cnt_q <= step ? '0 : cnt_q + 1'b1;
    end

endmodule

// File: rtl/pav_lfsr.sv
// Fibonacci shift register for polynomial x^W + x^TAP + 1.
// Shifts left on adv; output bit is the MSB. Reset seed is all ones,
// so the register never reaches the all-zero lock-up state.
module pav_lfsr #(
    parameter int W   = 4,
    parameter int TAP = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] state
);

    logic fb;

    // Feedback from the two polynomial terms.
    always_comb fb = state[W-1] ^ state[TAP-1];

    // Seed on reset, shift on advance.
    always_ff @(posedge clk) begin
        if (!rst_n)   state <= '1;
        else if (adv) state <= {state[W-2:0], fb};
    end

endmodule

// File: rtl/pav_wave_seq.sv
// Shared modulo counter and waveform selector.
// Assumes cfg.modulus >= 1; a modulus of 1 pins the counter at 0.
// wrap marks the advance at which the counter leaves its last value.
module pav_wave_seq
    import pav_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       step,
    input  voice_cfg_t cfg,
    input  logic       p4_bit,
    input  logic       p5_bit,
    input  logic       p9_bit,
    output logic       wave,
    output logic       wrap
);

    logic [MOD_W-1:0] cnt_q;
    logic [MOD_W-1:0] last_val;
    logic             cnt_adv;

    // Decide whether the counter moves and whether it wraps.
    always_comb begin
        last_val = cfg.modulus - 1'b1;
        cnt_adv  = step && (!cfg.div_on_p5 || p5_bit);
        wrap     = cnt_adv && (cnt_q >= last_val);
    end

    // Modulo counter; a control write restarts it.
    always_ff @(posedge clk) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clear)   cnt_q <= '0;
        else if (cnt_adv) cnt_q <= (cnt_q >= last_val) ? '0 : cnt_q + 1'b1;
    end

    // Select the waveform source for the active code.
    always_comb begin
        case (cfg.src)
            SRC_P4:  wave = p4_bit;
            SRC_P5:  wave = p5_bit;
            SRC_P9:  wave = p9_bit;
            SRC_DIV: wave = (cnt_q >= (cfg.modulus >> 1));
            default: wave = 1'b1;
        endcase
    end

endmodule

// File: rtl/poly_audio_voice.sv
// Top of one tone/noise voice: setting registers, rate prescaler,
// three noise registers, shared counter, and registered amplitude.
// Assumes FREQ_W >= VOL_W so control and volume fit in wr_data.
module poly_audio_voice
    import pav_pkg::*;
#(
    parameter int FREQ_W = 5,
    parameter int VOL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [FREQ_W-1:0] wr_data,
    output logic [VOL_W-1:0]  amp_out
);

    localparam int CTRL_W = 4;

    logic [FREQ_W-1:0] freq_q;
    logic [CTRL_W-1:0] ctrl_q;
    logic [VOL_W-1:0]  vol_q;
    logic              step;
    logic              ctrl_wr;
    logic              wave;
    logic              wrap;
    logic              p4_adv;
    logic [3:0]        p4_q;
    logic [4:0]        p5_q;
    logic [8:0]        p9_q;
    voice_cfg_t        cfg;

    // Setting writes; address 3 is a hole.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            freq_q <= '0;
            ctrl_q <= '0;
            vol_q  <= '0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                REG_FREQ: freq_q <= wr_data;
                REG_CTRL: ctrl_q <= wr_data[CTRL_W-1:0];
                REG_VOL:  vol_q  <= wr_data[VOL_W-1:0];
                default:  ;
            endcase
        end
    end

    // Decode the active code and the 4-bit register's gating.
    always_comb begin
        cfg     = decode_ctrl(ctrl_q);
        ctrl_wr = wr_en && (reg_addr_e'(wr_addr) == REG_CTRL);
        case (cfg.p4_clk)
            P4_ON_WRAP: p4_adv = wrap;
            P4_ON_P5:   p4_adv = step && p5_q[4];
            default:    p4_adv = step;
        endcase
    end

    pav_rate_div #(.FW(FREQ_W)) u_rate (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .div_val (freq_q),
        .step    (step)
    );

    pav_lfsr #(.W(4), .TAP(3)) u_p4 (
        .clk (clk), .rst_n (rst_n), .adv (p4_adv), .state (p4_q)
    );

    pav_lfsr #(.W(5), .TAP(3)) u_p5 (
        .clk (clk), .rst_n (rst_n), .adv (step), .state (p5_q)
    );

    pav_lfsr #(.W(9), .TAP(5)) u_p9 (
        .clk (clk), .rst_n (rst_n), .adv (step), .state (p9_q)
    );

    pav_wave_seq u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (ctrl_wr),
        .step   (step),
        .cfg    (cfg),
        .p4_bit (p4_q[3]),
        .p5_bit (p5_q[4]),
        .p9_bit (p9_q[8]),
        .wave   (wave),
        .wrap   (wrap)
    );

    // Gate the volume with the waveform into the output register.
    always_ff @(posedge clk) begin
        if (!rst_n) amp_out <= '0;
        else        amp_out <= wave ? vol_q : '0;
    end

endmodule

// File: rtl/pav_checker.sv
// Property checker for poly_audio_voice, attached with bind below.
// Observes ports plus the setting and noise registers of the top.
module pav_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       tick_en,
    input logic       wr_en,
    input logic [1:0] wr_addr,
    input logic       step,
    input logic [4:0] freq_q,
    input logic [3:0] ctrl_q,
    input logic [3:0] vol_q,
    input logic [3:0] p4_q,
    input logic [4:0] p5_q,
    input logic [8:0] p9_q,
    input logic [3:0] amp_out
);

    AST_AMP_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        amp_out != 4'd0 |-> amp_out == $past(vol_q)); // R9

    AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ctrl_q == 4'h0 || ctrl_q == 4'hB) |-> amp_out == $past(vol_q)); // R3

    AST_STEP_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> tick_en); // R2

    AST_FULL_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        (freq_q == 5'd0 && tick_en) |-> step); // R2

    AST_POLY_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        p4_q != 4'd0 && p5_q != 5'd0 && p9_q != 9'd0); // R4

    AST_P9_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(p9_q)); // R4

    AST_IGNORE_HOLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == 2'd3) |=> $stable(freq_q) && $stable(ctrl_q) && $stable(vol_q)); // R11

endmodule

bind poly_audio_voice pav_checker u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .step    (step),
    .freq_q  (freq_q),
    .ctrl_q  (ctrl_q),
    .vol_q   (vol_q),
    .p4_q    (p4_q),
    .p5_q    (p5_q),
    .p9_q    (p9_q),
    .amp_out (amp_out)
);

// File: tb/sim_poly_audio_voice.sv
`timescale 1ns/1ps
module sim_poly_audio_voice;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [4:0] wr_data = 5'd0;
    logic [3:0] amp_out;

    always #10 clk = ~clk;

    poly_audio_voice u0 (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .amp_out (amp_out)
    );

    int n_cmp = 0;
    int n_bad = 0;

    // Bench model of the voice, built from the requirements.
    logic [4:0] m_pre, m_freq;
    logic [3:0] m_ctrl, m_vol, m_p4;
    logic [4:0] m_p5;
    logic [8:0] m_p9;
    int         m_d;

    function automatic int mod_of(input logic [3:0] c);
        case (c)
            4'h2:             return 15;
            4'h4, 4'h5, 4'h7: return 2;
            4'h6, 4'hA:       return 31;
            4'hC, 4'hD, 4'hF: return 6;
            4'hE:             return 93;
            default:          return 1;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'h0, 4'hB:       return "R3";
            4'h1, 4'h8, 4'h9: return "R4";
            4'h2:             return "R5";
            4'h3:             return "R6";
            4'h7, 4'hF:       return "R8";
            default:          return "R7";
        endcase
    endfunction

    function automatic logic m_wave();
        case (m_ctrl)
            4'h0, 4'hB:       return 1'b1;
            4'h1, 4'h2, 4'h3: return m_p4[3];
            4'h8:             return m_p9[8];
            4'h9:             return m_p5[4];
            default:          return (m_d >= mod_of(m_ctrl) / 2);
        endcase
    endfunction

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: amp_out=%0d expected %0d (ctrl=%h freq=%0d vol=%0d)",
                     tag, act, exp, m_ctrl, m_freq, m_vol);
        end
    endtask

    task automatic chk_model(input string tag);
        check(tag, amp_out, m_wave() ? m_vol : 4'd0);
    endtask

    // One base tick through the model (R2 prescaler, R4..R8 stages).
    task automatic model_tick();
        logic p5b;
        int   md;
        logic cadv;
        logic wrp;
        logic p4a;
        if (m_pre >= m_freq) begin
            m_pre = 5'd0;
            p5b   = m_p5[4];
            md    = mod_of(m_ctrl);
            cadv  = !(m_ctrl == 4'h7 || m_ctrl == 4'hF) || p5b;
            wrp   = cadv && (m_d == md - 1);
            p4a   = (m_ctrl == 4'h2) ? wrp : (m_ctrl == 4'h3) ? p5b : 1'b1;
            if (p4a) m_p4 = {m_p4[2:0], m_p4[3] ^ m_p4[2]};
            m_p5 = {m_p5[3:0], m_p5[4] ^ m_p5[2]};
            m_p9 = {m_p9[7:0], m_p9[8] ^ m_p9[4]};
            if (cadv) m_d = (m_d >= md - 1) ? 0 : m_d + 1;
        end else begin
            m_pre = m_pre + 5'd1;
        end
    endtask

    task automatic do_tick(input string tag);
        @(negedge clk) tick_en = 1'b1;
        @(negedge clk) tick_en = 1'b0;
        model_tick();
        @(negedge clk);
        chk_model(tag);
    endtask

    task automatic do_write(input logic [1:0] a, input logic [4:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        case (a)
            2'd0: m_freq = d;
            2'd1: begin m_ctrl = d[3:0]; m_d = 0; end
            2'd2: m_vol = d[3:0];
            default: ;
        endcase
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        #(200000 * 20);
        n_bad++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        summary();
        $finish;
    end

    initial begin
        m_pre = '0; m_freq = '0; m_ctrl = '0; m_vol = '0;
        m_p4 = '1; m_p5 = '1; m_p9 = '1; m_d = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", amp_out, 4'd0);

        do_write(2'd2, 5'd15);
        check("R3", amp_out, 4'd15);
        do_write(2'd1, 5'd1);
        chk_model("R1");                 // seeded 4-bit MSB is 1

        // Every control code, mixed divisors and volumes.
        for (int c = 0; c < 16; c++) begin
            do_write(2'd0, 5'(c % 3));
            do_write(2'd2, 5'((c * 7 + 3) & 15));
            do_write(2'd1, 5'(c));
            chk_model(tag_of(4'(c)));
            repeat (300) do_tick(tag_of(4'(c)));
        end

        // R9: every volume with the waveform forced high.
        do_write(2'd1, 5'd0);
        for (int v = 0; v < 16; v++) begin
            do_write(2'd2, 5'(v));
            check("R9", amp_out, 4'(v));
        end

        // R2: every divisor, observed through the divide-by-2 mode.
        do_write(2'd2, 5'd15);
        for (int n = 0; n < 32; n++) begin
            do_write(2'd0, 5'(n));
            do_write(2'd1, 5'd4);
            repeat (2 * (n + 1) + 3) do_tick("R2");
        end

        // R10: control rewrite restarts the shared counter.
        do_write(2'd0, 5'd0);
        do_write(2'd1, 5'd14);
        repeat (60) do_tick("R7");
        check("R10", amp_out, 4'd15);
        do_write(2'd1, 5'd14);
        check("R10", amp_out, 4'd0);
        repeat (50) do_tick("R10");

        // R11: address 3 write alters nothing.
        do_write(2'd3, 5'h1F);
        chk_model("R11");
        repeat (40) do_tick("R11");

        summary();
        $finish;
    end

endmodule